// File: doc/BRIEF.md
# Inter-Thread Unit Configuration Tag Block

This block holds the configuration tags of an inter-thread communication unit. A simple 64-bit register bus reaches two address-map registers, at an 8-byte stride. The first register carries the base address and the enable of a relocatable storage window. The second carries an address-mask field that sets the window size, a small entry-grain field, and a read-only count of the storage cells. Writes are bit-masked, so bits that are read-only or unused keep their old contents.

The registered window parameters (base, size and enable) follow a register change by one clock. A size is applied only when it comes out as a power of two. A combinational hit output tells the surrounding logic when an address falls inside the enabled window.

The block also holds the reset-time tag of every storage cell: an empty flag, a FIFO flag and a depth code. FIFO cells come first, then semaphore cells.

Top module: `itc_cfg_tags`

## Requirements
- R1: After reset, register index 0 reads 0 and register index 1 reads 0x0000_0000_0200_0C00 with the default 32 cells (mask bits 16:10 = 0xC00, cell total at bit 20). The window has base 0, size 4096 and is disabled.
- R2: The register index is reg_addr shifted right by 3, so the low three address bits do not select a register (address 0x0F reads index 1).
- R3: A write to index 0 changes only bits 31:10 (base) and bit 0 (enable). Every other bit keeps its previous value.
- R4: A write to index 1 changes only bits 16:10 (mask) and bits 2:0 (grain). The cell-total field at bit 20 and all other bits keep their previous value.
- R5: win_base (index 0 bits 31:10 with the low 10 bits zero) and win_en (index 0 bit 0) take their new values on the second rising edge after the write edge, that is one clock after the register changes. They do not change in any cycle that does not follow a register change.
- R6: The candidate size is 1024 plus the value of index 1 bits 16:10 taken in place. win_size takes the candidate only if it is a power of two; otherwise it keeps its previous value.
- R7: win_hit is 1 exactly when win_en is 1 and win_base <= win_addr < win_base + win_size. The sum is computed without wrapping at 32 bits.
- R8: A write to any index other than 0 or 1 changes no register and no window parameter. A read of such an index returns 0.
- R9: After reset, cells 0 to NUM_FIFO-1 have empty = 1, fifo = 1 and depth = FIFO_DEPTH_CODE (2 by default). Cells NUM_FIFO and up have all three fields zero. All tags hold their value while the block runs.
- R10: A configuration with more than MAX_FIFO FIFO cells, more than MAX_SEM semaphore cells, or no cells at all stops elaboration with an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | BUS_AW | Register byte address |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Combinational read data for reg_addr |
| win_addr | input | 32 | Address tested against the window |
| win_hit | output | 1 | win_addr lies in the enabled window |
| win_base | output | 32 | Registered window base |
| win_size | output | 18 | Registered window size in bytes |
| win_en | output | 1 | Registered window enable |
| cell_empty | output | NUM_CELLS | Empty flag per cell |
| cell_fifo | output | NUM_CELLS | FIFO flag per cell |
| cell_depth | output | NUM_CELLS*DEPTH_W | Depth code per cell, cell 0 in the low bits |

## Verification
The bench writes all-ones to both registers. A design with a wrong write mask would corrupt the cell-total field or set unused bits. It also writes a mask that gives a 3072-byte candidate: a design without the power-of-two filter would resize to 3072 where 4096 must stay. The window is checked in the cycle right after the write, where a design without the one-clock latency would already show the new base. The window is placed at the top of the 32-bit space, where a 32-bit sum would wrap and lose the hit at 0xFFFFFFFF. A write to index 2 with all ones would show up in the readback or the window of a design that decodes only one address bit.

// File: rtl/itc_cfg_pkg.sv
package itc_cfg_pkg;
   localparam int REG_W  = 64;
   localparam int WADR_W = 32;
   localparam int SIZE_W = 18;
   localparam int CNT_LSB = 20;
   localparam logic [REG_W-1:0] AM0_WMASK = 64'h0000_0000_FFFF_FC01;
   localparam logic [REG_W-1:0] AM1_WMASK = 64'h0000_0000_0001_FC07;
   localparam logic [REG_W-1:0] AM1_MFLD  = 64'h0000_0000_0001_FC00;
   localparam logic [REG_W-1:0] AM1_RSTMASK = 64'h0000_0000_0000_0FFF;

   function automatic logic [SIZE_W-1:0] cand_size(input logic [REG_W-1:0] am1);
      return SIZE_W'(1024) + SIZE_W'(am1 & AM1_MFLD);
   endfunction

   function automatic logic is_pow2(input logic [SIZE_W-1:0] s);
      return (s != '0) && ((s & (s - SIZE_W'(1))) == '0);
   endfunction
endpackage

// File: rtl/itc_cfg_regs.sv
module itc_cfg_regs
   import itc_cfg_pkg::*;
#(
   parameter int BUS_AW    = 12,
   parameter int NUM_CELLS = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [BUS_AW-1:0] reg_addr,
   input  logic [REG_W-1:0]  reg_wdata,
   output logic [REG_W-1:0]  reg_rdata,
   output logic [REG_W-1:0]  am0,
   output logic [REG_W-1:0]  am1,
   output logic              cfg_chg
);
   localparam int IDX_W = BUS_AW - 3;
   localparam logic [REG_W-1:0] CNT_FLD = REG_W'(NUM_CELLS) << CNT_LSB;
   localparam logic [REG_W-1:0] AM1_RST = (AM1_RSTMASK & AM1_MFLD) | CNT_FLD;

   logic [IDX_W-1:0] idx;
   logic [REG_W-1:0] am0_d, am1_d;
   logic             chg_d;

   assign idx = reg_addr[BUS_AW-1:3];

   always_comb begin
      am0_d = am0;
      am1_d = am1;
      if (reg_wr) begin
         if (idx == IDX_W'(0))
            am0_d = (reg_wdata & AM0_WMASK) | (am0 & ~AM0_WMASK);
         else if (idx == IDX_W'(1))
            am1_d = (reg_wdata & AM1_WMASK) | (am1 & ~AM1_WMASK);
      end
      chg_d = (am0_d != am0) || (am1_d != am1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         am0     <= '0;
         am1     <= AM1_RST;
         cfg_chg <= 1'b0;
      end else begin
         am0     <= am0_d;
         am1     <= am1_d;
         cfg_chg <= chg_d;
      end
   end

   always_comb begin
      if (idx == IDX_W'(0))      reg_rdata = am0;
      else if (idx == IDX_W'(1)) reg_rdata = am1;
      else                       reg_rdata = '0;
   end

   // R3: bits outside the writable set of index 0 survive a write
   p_am0_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && idx == IDX_W'(0)) |=> ((am0 & ~AM0_WMASK) == $past(am0 & ~AM0_WMASK)));

   // R4: the cell-total field never moves
   p_cnt_fixed_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (am1 >> CNT_LSB) == (CNT_FLD >> CNT_LSB));

   // R8: writes to unmapped indices leave both registers alone
   p_unmapped_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && idx > IDX_W'(1)) |=> ($stable(am0) && $stable(am1)));
endmodule

// File: rtl/itc_cfg_window.sv
module itc_cfg_window
   import itc_cfg_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_chg,
   input  logic [REG_W-1:0]  am0,
   input  logic [REG_W-1:0]  am1,
   input  logic [WADR_W-1:0] win_addr,
   output logic              win_hit,
   output logic [WADR_W-1:0] win_base,
   output logic [SIZE_W-1:0] win_size,
   output logic              win_en
);
   localparam logic [REG_W-1:0] AM1_RST = AM1_RSTMASK & AM1_MFLD;
   localparam logic [SIZE_W-1:0] SIZE_RST = cand_size(AM1_RST);

   logic [SIZE_W-1:0] cand;
   logic [WADR_W:0]   lo_x, hi_x, a_x;

   assign cand = cand_size(am1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win_base <= '0;
         win_en   <= 1'b0;
         win_size <= SIZE_RST;
      end else if (cfg_chg) begin
         win_base <= {am0[WADR_W-1:10], 10'd0};
         win_en   <= am0[0];
         if (is_pow2(cand)) win_size <= cand;
      end
   end

   assign a_x  = {1'b0, win_addr};
   assign lo_x = {1'b0, win_base};
   assign hi_x = lo_x + (WADR_W+1)'(win_size);
   assign win_hit = win_en && (a_x >= lo_x) && (a_x < hi_x);

   // R6: the applied size is always a power of two
   p_size_pow2_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(win_size) == 1);

   // R5: window parameters move only after a register change
   p_win_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(cfg_chg) |-> ($stable(win_base) && $stable(win_en) && $stable(win_size)));

   // R7: no hit while the window is off
   p_hit_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
      win_hit |-> win_en);
endmodule

// File: rtl/itc_cell_tags.sv
module itc_cell_tags #(
   parameter int NUM_FIFO   = 16,
   parameter int NUM_SEM    = 16,
   parameter int DEPTH_W    = 4,
   parameter int DEPTH_CODE = 2
) (
   input  logic                           clk,
   input  logic                           rst_n,
   output logic [NUM_FIFO+NUM_SEM-1:0]    cell_empty,
   output logic [NUM_FIFO+NUM_SEM-1:0]    cell_fifo,
   output logic [(NUM_FIFO+NUM_SEM)*DEPTH_W-1:0] cell_depth
);
   localparam int NUM_CELLS = NUM_FIFO + NUM_SEM;

   for (genvar i = 0; i < NUM_CELLS; i++) begin : g_cell
      logic               e_q, f_q;
      logic [DEPTH_W-1:0] d_q;
      if (i < NUM_FIFO) begin : g_fifo
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               e_q <= 1'b1;
               f_q <= 1'b1;
               d_q <= DEPTH_W'(DEPTH_CODE);
            end else begin
               e_q <= e_q;
               f_q <= f_q;
               d_q <= d_q;
            end
         end
      end else begin : g_sem
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               e_q <= 1'b0;
               f_q <= 1'b0;
               d_q <= '0;
            end else begin
               e_q <= e_q;
               f_q <= f_q;
               d_q <= d_q;
            end
         end
      end
      assign cell_empty[i] = e_q;
      assign cell_fifo[i]  = f_q;
      assign cell_depth[i*DEPTH_W +: DEPTH_W] = d_q;
   end

   // R9: cell tags hold while running
   p_tags_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $stable(cell_empty) && $stable(cell_fifo) && $stable(cell_depth));
endmodule

// File: rtl/itc_cfg_tags.sv
module itc_cfg_tags
   import itc_cfg_pkg::*;
#(
   parameter int NUM_FIFO        = 16,
   parameter int NUM_SEM         = 16,
   parameter int MAX_FIFO        = 16,
   parameter int MAX_SEM         = 16,
   parameter int BUS_AW          = 12,
   parameter int DEPTH_W         = 4,
   parameter int FIFO_DEPTH_CODE = 2,
   localparam int NUM_CELLS      = NUM_FIFO + NUM_SEM
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           reg_wr,
   input  logic [BUS_AW-1:0]              reg_addr,
   input  logic [63:0]                    reg_wdata,
   output logic [63:0]                    reg_rdata,
   input  logic [31:0]                    win_addr,
   output logic                           win_hit,
   output logic [31:0]                    win_base,
   output logic [17:0]                    win_size,
   output logic                           win_en,
   output logic [NUM_CELLS-1:0]           cell_empty,
   output logic [NUM_CELLS-1:0]           cell_fifo,
   output logic [NUM_CELLS*DEPTH_W-1:0]   cell_depth
);
   // R10: configuration limits
   if (NUM_FIFO > MAX_FIFO) begin : g_bad_fifo
      $error("itc_cfg_tags: too many FIFO cells (%0d)", NUM_FIFO);
   end
   if (NUM_SEM > MAX_SEM) begin : g_bad_sem
      $error("itc_cfg_tags: too many semaphore cells (%0d)", NUM_SEM);
   end
   if (NUM_CELLS < 1) begin : g_bad_none
      $error("itc_cfg_tags: at least one cell is required");
   end
   if (BUS_AW < 4) begin : g_bad_aw
      $error("itc_cfg_tags: BUS_AW must be at least 4");
   end
   if (FIFO_DEPTH_CODE >= (1 << DEPTH_W)) begin : g_bad_depth
      $error("itc_cfg_tags: depth code does not fit DEPTH_W");
   end

   logic [REG_W-1:0] am0, am1;
   logic             cfg_chg;

   itc_cfg_regs #(.BUS_AW(BUS_AW), .NUM_CELLS(NUM_CELLS)) u_regs (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .am0(am0), .am1(am1), .cfg_chg(cfg_chg)
   );

   itc_cfg_window u_win (
      .clk(clk), .rst_n(rst_n), .cfg_chg(cfg_chg), .am0(am0), .am1(am1),
      .win_addr(win_addr), .win_hit(win_hit), .win_base(win_base),
      .win_size(win_size), .win_en(win_en)
   );

   itc_cell_tags #(.NUM_FIFO(NUM_FIFO), .NUM_SEM(NUM_SEM), .DEPTH_W(DEPTH_W),
                   .DEPTH_CODE(FIFO_DEPTH_CODE)) u_cells (
      .clk(clk), .rst_n(rst_n), .cell_empty(cell_empty),
      .cell_fifo(cell_fifo), .cell_depth(cell_depth)
   );
endmodule

// File: tb/itc_cfg_tags_tb.sv
module itc_cfg_tags_tb;
   localparam int NF = 16, NS = 16, NC = NF + NS, DW = 4, AW = 12;

   logic clk = 0, rst_n = 0, reg_wr = 0;
   logic [AW-1:0] reg_addr = '0;
   logic [63:0] reg_wdata = '0, reg_rdata;
   logic [31:0] win_addr = '0, win_base;
   logic [17:0] win_size;
   logic win_hit, win_en;
   logic [NC-1:0] cell_empty, cell_fifo;
   logic [NC*DW-1:0] cell_depth;
   int n_chk = 0, n_fail = 0, cyc = 0;
   bit done = 0;

   always #5 clk = ~clk;

   itc_cfg_tags u_dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .win_addr(win_addr),
      .win_hit(win_hit), .win_base(win_base), .win_size(win_size),
      .win_en(win_en), .cell_empty(cell_empty), .cell_fifo(cell_fifo),
      .cell_depth(cell_depth)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [63:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1;
      @(negedge clk);
      reg_wr = 0;
   endtask

   task automatic rd(input logic [AW-1:0] a, output logic [63:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic hit_at(input logic [31:0] a, input logic exp, input string req);
      win_addr = a;
      #1 chk(req, 64'(win_hit), 64'(exp));
   endtask

   task automatic t_reset;
      logic [63:0] d;
      rd(12'h000, d); chk("R1 am0 reset", d, 64'h0);
      rd(12'h008, d); chk("R1 am1 reset", d, 64'h0200_0C00);
      chk("R1 base reset", 64'(win_base), 64'h0);
      chk("R1 size reset", 64'(win_size), 64'd4096);
      chk("R1 en reset", 64'(win_en), 64'h0);
   endtask

   task automatic t_index;
      logic [63:0] d;
      rd(12'h00F, d); chk("R2 addr 0x0F reads index 1", d, 64'h0200_0C00);
      rd(12'h005, d); chk("R2 addr 0x05 reads index 0", d, 64'h0);
   endtask

   task automatic t_am0_mask;
      logic [63:0] d;
      wr(12'h000, '1);
      rd(12'h000, d); chk("R3 am0 all-ones write", d, 64'hFFFF_FC01);
      wr(12'h000, 64'h0);
      rd(12'h000, d); chk("R3 am0 clear", d, 64'h0);
   endtask

   task automatic t_am1_mask;
      logic [63:0] d;
      wr(12'h008, '1);
      rd(12'h008, d); chk("R4 am1 all-ones write", d, 64'h0201_FC07);
      @(negedge clk);
      chk("R6 size 131072 applied", 64'(win_size), 64'd131072);
      wr(12'h008, 64'h0);
      rd(12'h008, d); chk("R4 count field kept", d, 64'h0200_0000);
   endtask

   task automatic t_size;
      logic [63:0] d;
      wr(12'h008, 64'h0C00);
      @(negedge clk); chk("R6 size 4096", 64'(win_size), 64'd4096);
      wr(12'h008, 64'h0800);
      @(negedge clk); chk("R6 size 3072 rejected", 64'(win_size), 64'd4096);
      rd(12'h008, d); chk("R6 mask still stored", d, 64'h0200_0800);
      wr(12'h008, 64'h0);
      @(negedge clk); chk("R6 size 1024", 64'(win_size), 64'd1024);
   endtask

   task automatic t_window;
      wr(12'h000, 64'h0001_0001);
      chk("R5 base not yet moved", 64'(win_base), 64'h0);
      chk("R5 en not yet set", 64'(win_en), 64'h0);
      @(negedge clk);
      chk("R5 base moved", 64'(win_base), 64'h1_0000);
      chk("R5 en set", 64'(win_en), 64'h1);
      hit_at(32'h0001_0000, 1, "R7 hit at base");
      hit_at(32'h0001_03FF, 1, "R7 hit at last byte");
      hit_at(32'h0001_0400, 0, "R7 miss at end");
      hit_at(32'h0000_FFFF, 0, "R7 miss below base");
      wr(12'h000, 64'h0001_0000);
      @(negedge clk);
      hit_at(32'h0001_0000, 0, "R7 miss while disabled");
      wr(12'h000, 64'hFFFF_FC01);
      @(negedge clk);
      hit_at(32'hFFFF_FFFF, 1, "R7 hit at top of space");
      hit_at(32'hFFFF_FBFF, 0, "R7 miss below top window");
   endtask

   task automatic t_unmapped;
      logic [63:0] d;
      wr(12'h010, '1);
      @(negedge clk);
      rd(12'h000, d); chk("R8 am0 untouched", d, 64'hFFFF_FC01);
      rd(12'h008, d); chk("R8 am1 untouched", d, 64'h0200_0000);
      chk("R8 size untouched", 64'(win_size), 64'd1024);
      chk("R8 base untouched", 64'(win_base), 64'hFFFF_FC00);
      rd(12'h010, d); chk("R8 index 2 reads zero", d, 64'h0);
      rd(12'h0F8, d); chk("R8 index 31 reads zero", d, 64'h0);
   endtask

   task automatic t_cells;
      @(negedge clk);
      for (int i = 0; i < NC; i++) begin
         chk($sformatf("R9 cell %0d empty", i), 64'(cell_empty[i]), (i < NF) ? 64'h1 : 64'h0);
         chk($sformatf("R9 cell %0d fifo", i), 64'(cell_fifo[i]), (i < NF) ? 64'h1 : 64'h0);
         chk($sformatf("R9 cell %0d depth", i), 64'(cell_depth[i*DW +: DW]), (i < NF) ? 64'h2 : 64'h0);
      end
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 20000 && !done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      t_reset;
      t_index;
      t_am0_mask;
      t_am1_mask;
      t_size;
      t_window;
      t_unmapped;
      t_cells;
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule